// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block collects up to 31 interrupt request lines, numbered 1 to 31, and presents a single active-low interrupt line to a processor. A rising edge on a request line latches a pending bit that stays set until software clears it. A separate enable mask decides which pending bits may interrupt. Software reaches every register through a small word-addressed read/write port.

Software can service interrupts in two ways. In the first, it reads a status word that shows every source that is both pending and enabled, and picks one itself. In the second, it reads a vector word. The controller then arbitrates among the pending-and-enabled sources using a 3-bit priority level held per source, and returns the winning source number shifted left by two. That value is a word-aligned offset into a handler table. The same read records the winner in a source-number register, which holds it until software writes the end-of-service address.

Top module: `prio_vec_intc`

## Requirements
- R1: After a synchronous reset, every register reads zero, `bus_rdata` is zero and `irq_n` is high.
- R2: On a clock where `src_req[n]` is high and was low at the previous clock, pending bit n is set. Bit n of every source-indexed word corresponds to source n, and bit 0 always reads 0. A held-high request does not set the bit again once software has cleared it.
- R3: A write to address 0x21 clears every pending bit written as 1. Address 0x21 reads the pending bits. A new rising edge in the same cycle wins over the clear.
- R4: A write to address 0x23 sets the enable bits written as 1. A write to address 0x24 clears the enable bits written as 1. Address 0x22 reads the enable bits, and bit 0 stays 0.
- R5: Address 0x20 reads the bitwise AND of the pending and enable bits.
- R6: `irq_n` is low exactly when some bit is both pending and enabled. It changes on the same clock edge as the registers it depends on.
- R7: Address n, for n from 1 to 31, holds the priority level of source n in bits 2:0. All other bits of that address read 0.
- R8: A read of address 0x25 returns the winning source number times 4, or 0 when nothing is pending and enabled. The winner has the numerically lowest level, and the lowest source number breaks a tie.
- R9: A read of address 0x25 copies the winning source number into the register at address 0x26. The value stays there until the next such read or an end-of-service write.
- R10: A write to address 0x27 (end of service) clears the register at address 0x26.
- R11: Read data appears on `bus_rdata` one clock after `bus_rd` is sampled and holds until the next read. Address 0 and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_req | input | 31 | Request lines, bit n is source n (n = 1..31) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_n | output | 1 | Interrupt to processor, active low |

## Verification
The embedded assertions check the following on every cycle:
- `irq_n` agrees with the pending and enable registers.
- A fresh edge always leaves its pending bit set.
- A clear leaves no written bit set unless a new edge arrived in that cycle.
- An enable-set write takes effect.
- The arbiter's winner is always a pending source, and it is zero when nothing is pending.
- The source-number register follows vector reads and end-of-service writes.

Some behaviours depend on sequences of events, and only the bench's scenarios can show them:
- Tie-breaking by source number, and a level-0 source pre-empting an earlier winner.
- A held request not re-arming after a clear.
- Register read-back and the zero masking of bit 0.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] A_PEND    = 6'h20;
  localparam logic [ADDR_W-1:0] A_ACTIVE  = 6'h21;
  localparam logic [ADDR_W-1:0] A_ENABLE  = 6'h22;
  localparam logic [ADDR_W-1:0] A_ENA_SET = 6'h23;
  localparam logic [ADDR_W-1:0] A_ENA_CLR = 6'h24;
  localparam logic [ADDR_W-1:0] A_VECTOR  = 6'h25;
  localparam logic [ADDR_W-1:0] A_SRCNUM  = 6'h26;
  localparam logic [ADDR_W-1:0] A_EOS     = 6'h27;
endpackage

// File: rtl/pvic_capture.sv
module pvic_capture #(
  parameter int NUM_SRC = 31
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC:1]   src_req,
  input  logic               clr_stb,
  input  logic               set_en_stb,
  input  logic               clr_en_stb,
  input  logic [NUM_SRC:1]   wmask,
  output logic [NUM_SRC:1]   active_q,
  output logic [NUM_SRC:1]   enable_q,
  output logic               irq_n
);
  logic [NUM_SRC:1] req_q, rise, act_d, en_d;

  assign rise = src_req & ~req_q;

  always_comb begin
    act_d = active_q;
    if (clr_stb) act_d = act_d & ~wmask;
    act_d = act_d | rise;
    en_d = enable_q;
    if (set_en_stb) en_d = en_d | wmask;
    if (clr_en_stb) en_d = en_d & ~wmask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q    <= '0;
      active_q <= '0;
      enable_q <= '0;
      irq_n    <= 1'b1;
    end else begin
      req_q    <= src_req;
      active_q <= act_d;
      enable_q <= en_d;
      irq_n    <= ~|(act_d & en_d);
    end
  end

  assert_edge_latches_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(rise) & ~active_q) == '0));
  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (rst)
    clr_stb |=> ((active_q & $past(wmask & ~rise)) == '0));
  assert_enable_set_R4: assert property (@(posedge clk) disable iff (rst)
    set_en_stb |=> ((enable_q & $past(wmask)) == $past(wmask)));
  assert_irq_tracks_R6: assert property (@(posedge clk) disable iff (rst)
    irq_n == ((active_q & enable_q) == '0));
endmodule

// File: rtl/pvic_prio_bank.sv
module pvic_prio_bank #(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 3,
  parameter int IDX_W   = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_stb,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [PRIO_W-1:0]             wr_level,
  output logic [NUM_SRC:1][PRIO_W-1:0]  level_q
);
  for (genvar n = 1; n <= NUM_SRC; n++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (rst) level_q[n] <= '0;
      else if (wr_stb && wr_idx == IDX_W'(n)) level_q[n] <= wr_level;
    end
  end
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter #(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 3,
  parameter int IDX_W   = 5
) (
  input  logic [NUM_SRC:1]              pend,
  input  logic [NUM_SRC:1][PRIO_W-1:0]  level,
  output logic [IDX_W-1:0]              win
);
  logic [PRIO_W-1:0] best;
  logic              found;

  always_comb begin
    best  = '1;
    found = 1'b0;
    win   = '0;
    for (int n = 1; n <= NUM_SRC; n++) begin
      if (pend[n] && (!found || level[n] < best)) begin
        found = 1'b1;
        best  = level[n];
        win   = IDX_W'(n);
      end
    end
  end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import pvic_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 3,
  parameter int DATA_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SRC:1]     src_req,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 irq_n
);
  localparam int IDX_W = $clog2(NUM_SRC + 1);

  logic [NUM_SRC:1]             active, enable, pend;
  logic [NUM_SRC:0]             pend0;
  logic [NUM_SRC:1][PRIO_W-1:0] level;
  logic [IDX_W-1:0]             win, srcnum_q;
  logic                         addr_is_src, vec_rd, eos_wr;
  logic [DATA_W-1:0]            rd_mux;

  assign addr_is_src = (bus_addr != '0) && (int'(bus_addr) <= NUM_SRC);
  assign vec_rd      = bus_rd && bus_addr == A_VECTOR;
  assign eos_wr      = bus_wr && bus_addr == A_EOS;
  assign pend        = active & enable;
  assign pend0       = {pend, 1'b0};

  pvic_capture #(.NUM_SRC(NUM_SRC)) u_capture (
    .clk(clk), .rst(rst), .src_req(src_req),
    .clr_stb(bus_wr && bus_addr == A_ACTIVE),
    .set_en_stb(bus_wr && bus_addr == A_ENA_SET),
    .clr_en_stb(bus_wr && bus_addr == A_ENA_CLR),
    .wmask(bus_wdata[NUM_SRC:1]),
    .active_q(active), .enable_q(enable), .irq_n(irq_n)
  );

  pvic_prio_bank #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst(rst),
    .wr_stb(bus_wr && addr_is_src),
    .wr_idx(bus_addr[IDX_W-1:0]),
    .wr_level(bus_wdata[PRIO_W-1:0]),
    .level_q(level)
  );

  pvic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
    .pend(pend), .level(level), .win(win)
  );

  always_comb begin
    rd_mux = '0;
    if (addr_is_src) begin
      for (int n = 1; n <= NUM_SRC; n++)
        if (bus_addr[IDX_W-1:0] == IDX_W'(n)) rd_mux = DATA_W'(level[n]);
    end else begin
      case (bus_addr)
        A_PEND:   rd_mux = DATA_W'({pend, 1'b0});
        A_ACTIVE: rd_mux = DATA_W'({active, 1'b0});
        A_ENABLE: rd_mux = DATA_W'({enable, 1'b0});
        A_VECTOR: rd_mux = DATA_W'({win, 2'b00});
        A_SRCNUM: rd_mux = DATA_W'(srcnum_q);
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      srcnum_q  <= '0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      if (eos_wr) srcnum_q <= '0;
      else if (vec_rd) srcnum_q <= win;
    end
  end

  assert_no_pend_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (pend == '0) |-> (win == '0));
  assert_winner_pending_R8: assert property (@(posedge clk) disable iff (rst)
    (win != '0) |-> pend0[win]);
  assert_srcnum_capture_R9: assert property (@(posedge clk) disable iff (rst)
    (vec_rd && !eos_wr) |=> (srcnum_q == $past(win)));
  assert_eos_clears_R10: assert property (@(posedge clk) disable iff (rst)
    eos_wr |=> (srcnum_q == '0));
endmodule

// File: tb/prio_vec_intc_tb.sv
module prio_vec_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:1] src = '0;
  logic        b_wr = 1'b0, b_rd = 1'b0;
  logic [5:0]  b_addr = '0;
  logic [31:0] b_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_n;
  int checks = 0, errors = 0;
  bit started = 0;

  always #2 clk = ~clk;

  prio_vec_intc dut_i (
    .clk(clk), .rst(rst), .src_req(src), .bus_wr(b_wr), .bus_rd(b_rd),
    .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  // reference model state
  int          m_prio [32];
  logic [31:0] m_act, m_en, m_reqq, m_rdata, m_pend;
  int          m_src, m_win;

  function automatic int ref_winner(logic [31:0] p);
    int best = 8, w = 0;
    for (int n = 1; n < 32; n++)
      if (p[n] && m_prio[n] < best) begin best = m_prio[n]; w = n; end
    return w;
  endfunction

  function automatic logic [31:0] ref_read(logic [5:0] a, logic [31:0] p, int w);
    if (a >= 1 && a <= 31) return 32'(m_prio[a]);
    case (a)
      6'h20: return p;
      6'h21: return m_act;
      6'h22: return m_en;
      6'h25: return 32'(w * 4);
      6'h26: return 32'(m_src);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      for (int n = 0; n < 32; n++) m_prio[n] = 0;
      m_act = 0; m_en = 0; m_reqq = 0; m_rdata = 0; m_src = 0;
    end else begin
      m_pend = m_act & m_en;
      m_win  = ref_winner(m_pend);
      if (b_rd) begin
        m_rdata = ref_read(b_addr, m_pend, m_win);
        if (b_addr == 6'h25) m_src = m_win;
      end
      if (b_wr) begin
        if (b_addr >= 1 && b_addr <= 31) m_prio[b_addr] = int'(b_wdata[2:0]);
        case (b_addr)
          6'h21: m_act = m_act & ~b_wdata;
          6'h23: m_en = (m_en | b_wdata) & 32'hFFFF_FFFE;
          6'h24: m_en = m_en & ~b_wdata;
          6'h27: m_src = 0;
          default: ;
        endcase
      end
      m_act  = (m_act | ({src, 1'b0} & ~m_reqq)) & 32'hFFFF_FFFE;
      m_reqq = {src, 1'b0};
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (started) begin
      chk(irq_n == ((m_act & m_en) == 0), "R6 irq vs model", 32'(irq_n), 32'((m_act & m_en) == 0));
      chk(bus_rdata == m_rdata, "R11 rdata vs model", bus_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); b_wr = 1; b_addr = a; b_wdata = d;
    @(negedge clk); b_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); b_rd = 1; b_addr = a;
    @(negedge clk); b_rd = 0;
    chk(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  task automatic set_src(input int n, input bit v);
    @(negedge clk); src[n] = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk(irq_n == 1'b1, "R1 irq_n after reset", 32'(irq_n), 32'h1);
    chk(bus_rdata == 0, "R1 rdata after reset", bus_rdata, 0);
    rd(6'h20, 0, "R1 pend reset");
    rd(6'h21, 0, "R1 active reset");
    rd(6'h22, 0, "R1 enable reset");
    rd(6'h25, 0, "R8 vector empty");
    // priorities
    wr(6'd3, 5); wr(6'd5, 2); wr(6'd9, 2); wr(6'd20, 0); wr(6'd31, 7);
    wr(6'd7, 32'hFFFF_FFFF);
    rd(6'd5, 2, "R7 level readback");
    rd(6'd7, 7, "R7 upper bits zero");
    // requests without enable
    set_src(5, 1); set_src(9, 1);
    rd(6'h21, 32'h220, "R2 active after edges");
    rd(6'h20, 0, "R5 pend masked");
    chk(irq_n == 1'b1, "R6 irq high when masked", 32'(irq_n), 1);
    wr(6'h23, 32'h0010_0220);
    rd(6'h22, 32'h0010_0220, "R4 enable set");
    rd(6'h20, 32'h220, "R5 pend and");
    chk(irq_n == 1'b0, "R6 irq low", 32'(irq_n), 0);
    rd(6'h25, 20, "R8 tie lowest number");
    rd(6'h26, 5, "R9 srcnum captured");
    set_src(20, 1);
    rd(6'h25, 80, "R8 level zero wins");
    rd(6'h26, 20, "R9 srcnum update");
    wr(6'h24, 32'h0010_0000);
    rd(6'h22, 32'h220, "R4 enable clear");
    rd(6'h25, 20, "R8 after disable");
    wr(6'h21, 32'h20);
    rd(6'h21, 32'h0010_0200, "R3 w1c one bit");
    rd(6'h25, 36, "R8 next winner");
    wr(6'h21, 32'h200);
    rd(6'h21, 32'h0010_0000, "R2 held request not rearmed");
    chk(irq_n == 1'b1, "R6 irq released", 32'(irq_n), 1);
    rd(6'h25, 0, "R8 none pending");
    wr(6'h27, 0);
    rd(6'h26, 0, "R10 eos clears");
    wr(6'h23, 32'h0010_0000);
    rd(6'h25, 80, "R8 reenabled");
    rd(6'h26, 20, "R9 srcnum holds");
    wr(6'h27, 32'hFFFF_FFFF);
    rd(6'h26, 0, "R10 eos clears again");
    // edge and clear in the same cycle
    @(negedge clk); src[3] = 1; b_wr = 1; b_addr = 6'h21; b_wdata = 32'h8;
    @(negedge clk); b_wr = 0;
    rd(6'h21, 32'h0010_0008, "R3 edge wins over clear");
    rd(6'd0, 0, "R11 address zero");
    rd(6'h3F, 0, "R11 unmapped");
    // boundary source 31
    wr(6'h24, 32'hFFFF_FFFF); wr(6'h21, 32'hFFFF_FFFF);
    wr(6'h23, 32'h8000_0001);
    rd(6'h22, 32'h8000_0000, "R4 bit0 ignored");
    set_src(31, 1);
    rd(6'h25, 124, "R8 source 31");
    chk(irq_n == 1'b0, "R6 irq for 31", 32'(irq_n), 0);
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule